// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is the target side of a two-wire SMBus/I2C link that gives a host access to a 16-byte register file. The host selects a starting register and then moves a run of bytes in either direction. Every block transfer carries a byte count. On writes, the host sends the count after the starting index. On reads, the target returns the count as the first data byte, and the indexed registers follow it.

The block oversamples the clock and data lines with the system clock. The data line is open-drain: it arrives as a plain input, and the target pulls it low through an output-enable. The 7-bit target address is a base value with two bits taken from address-select pins. The core logic sees every register value, plus a one-cycle write strobe and a one-cycle read strobe for each register. Registers 12 to 15 are read-only constants. Register 8 holds the count that reads report.

The controller is one state machine with nine states:
- ST_IDLE is the reset state and the state after a stop.
- ST_RX_ADDR, ST_RX_INDEX, ST_RX_COUNT and ST_RX_DATA shift in host bytes.
- ST_ACK_DRV pulls SDA low for one ninth clock and then moves to a stored return state.
- ST_TX_BYTE shifts a byte out.
- ST_ACK_GET samples the host's acknowledge.
- ST_WAIT_STOP ignores the bus until the next start or stop.

The transitions are as follows:
- A start moves any state to ST_RX_ADDR. A stop moves any state to ST_IDLE.
- After the address byte, a matching write goes ST_RX_ADDR→ST_ACK_DRV→ST_RX_INDEX. A matching read goes ST_RX_ADDR→ST_ACK_DRV→ST_TX_BYTE. Any other address goes to ST_WAIT_STOP.
- Writes continue ST_RX_INDEX→ST_ACK_DRV→ST_RX_COUNT→ST_ACK_DRV→ST_RX_DATA. Each counted data byte goes ST_RX_DATA→ST_ACK_DRV→ST_RX_DATA. A byte past the count goes ST_RX_DATA→ST_WAIT_STOP.
- Reads loop ST_TX_BYTE→ST_ACK_GET→ST_TX_BYTE while the host acknowledges. A host not-acknowledge moves ST_ACK_GET→ST_WAIT_STOP.

Top module: `smb_blkreg_target`

## Requirements
- R1: The target answers only its own 7-bit address, which is 0x36 XOR (addr_sel_i << 4). With the pins at 0 the bus bytes are 0x6C for a write and 0x6D for a read. Any other address byte is not acknowledged, and every byte after it is ignored until the next start.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A start abandons any partial byte and begins a new address byte. A stop returns the target to idle with SDA released.
- R3: SDA is sampled on SCL rising edges. The target changes its SDA drive only while SCL is low, and it holds an acknowledge low for the whole ninth clock.
- R4: A write is the address, then an index byte (its low 4 bits are the start register N), then a count byte X, then data. The first X data bytes are acknowledged and stored in registers N, N+1, …. Each stored byte pulses that register's write strobe once.
- R5: The register index advances after every data byte and wraps from 15 to 0.
- R6: Registers 12 to 15 read as the constants 0xC0+i. Writes to them are acknowledged but change nothing and raise no write strobe.
- R7: Data bytes beyond the write count are not acknowledged and are discarded.
- R8: A read is the write address, the index N, a repeated start and the read address. The target then returns the value of register 8, followed by registers N, N+1, … with wrap. Each register byte loaded for sending pulses its read strobe once.
- R9: Register 8 is writable. Its value is the count that later reads return first.
- R10: After the host does not acknowledge a read byte, the target keeps SDA released until the next start or stop.
- R11: After reset SDA is released, register 8 holds 8, registers 0 to 11 except register 8 hold 0, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | When high, the target pulls the data line low |
| addr_sel_i | input | 2 | Address-select pins (XOR into address bits 5:4) |
| reg_q_o | output | 128 | All register values, register i at bits 8i+7:8i |
| reg_wr_stb_o | output | 16 | One-cycle pulse per register written |
| reg_rd_stb_o | output | 16 | One-cycle pulse per register loaded for a read |

## Verification
The assertions check on every cycle that:
- a start always re-arms the address phase with a cleared bit counter, and a stop always returns to idle with SDA released;
- the target only begins pulling SDA while SCL is low, and holds the pull for the whole acknowledge state;
- SDA stays released in the idle and waiting states;
- the strobes are at most one-hot, and read-only registers never strobe.

Only the bench scenarios can show the values that travel on the bus. These are the count byte placed before the register bytes, the index wrap, discarded read-only writes, the refusal of surplus bytes and foreign addresses, and an aborted byte recovering at the next start. The bench checks them against a register model.

// File: rtl/smb_pkg.sv
package smb_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RX_ADDR,
        ST_RX_INDEX,
        ST_RX_COUNT,
        ST_RX_DATA,
        ST_ACK_DRV,
        ST_TX_BYTE,
        ST_ACK_GET,
        ST_WAIT_STOP
    } smb_state_e;

    localparam int BUS_BITS = 8;
    typedef logic [BUS_BITS-1:0] bus_byte_t;
endpackage

// File: rtl/smb_line_cond.sv
module smb_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;

    // idle bus is high on both lines, so reset to ones avoids false events
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
    parameter int                 N_REGS  = 16,
    parameter int                 DW      = 8,
    parameter logic [N_REGS-1:0]  RO_MASK = 16'hF000,
    parameter int                 CNT_IDX = 8,
    parameter logic [DW-1:0]      CNT_RST = 8'd8,
    parameter logic [DW-1:0]      RO_BASE = 8'hC0,
    localparam int                IW      = $clog2(N_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic [DW-1:0]        wr_data,
    input  logic                 rd_en,
    input  logic [IW-1:0]        rd_idx,
    output logic [DW-1:0]        cnt_val,
    output logic [N_REGS*DW-1:0] regs_flat,
    output logic [N_REGS-1:0]    wr_stb,
    output logic [N_REGS-1:0]    rd_stb
);
    logic [DW-1:0] val [N_REGS];

    for (genvar gi = 0; gi < N_REGS; gi++) begin : g_reg
        if (RO_MASK[gi]) begin : g_ro
            assign val[gi] = DW'(RO_BASE + gi);
        end else begin : g_rw
            localparam logic [DW-1:0] RST_V = (gi == CNT_IDX) ? CNT_RST : '0;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                         val[gi] <= RST_V;
                else if (wr_en && wr_idx == IW'(gi)) val[gi] <= wr_data;
            end
        end
        assign regs_flat[gi*DW +: DW] = val[gi];
    end

    assign cnt_val = val[CNT_IDX];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb <= '0;
            rd_stb <= '0;
        end else begin
            wr_stb <= wr_en ? ((N_REGS'(1) << wr_idx) & ~RO_MASK) : '0;
            rd_stb <= rd_en ? (N_REGS'(1) << rd_idx) : '0;
        end
    end

    AST_WSTB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb)); // R4
    AST_RO_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb & RO_MASK) == '0); // R6
    AST_RSTB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_stb)); // R8
endmodule

// File: rtl/smb_blkreg_target.sv
module smb_blkreg_target
    import smb_pkg::*;
#(
    parameter int                N_REGS    = 16,
    parameter logic [6:0]        BASE_ADDR = 7'h36,
    parameter int                SEL_W     = 2,
    parameter int                SEL_LSB   = 4,
    parameter logic [N_REGS-1:0] RO_MASK   = 16'hF000,
    parameter int                CNT_IDX   = 8,
    parameter logic [7:0]        CNT_RST   = 8'd8,
    parameter logic [7:0]        RO_BASE   = 8'hC0,
    localparam int               IW        = $clog2(N_REGS),
    localparam int               DW        = BUS_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe_o,
    input  logic [SEL_W-1:0]     addr_sel_i,
    output logic [N_REGS*DW-1:0] reg_q_o,
    output logic [N_REGS-1:0]    reg_wr_stb_o,
    output logic [N_REGS-1:0]    reg_rd_stb_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    smb_line_cond #(.SYNC_STAGES(2)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_state_e state, state_n, after;
    bus_byte_t  shreg, txsh, left;
    logic [3:0] bitn, txn;
    logic [IW-1:0] idx, wr_idx, rd_idx;
    logic [DW-1:0] wr_data, cnt_val, cur_byte, load_byte;
    logic       wr_en, rd_en, first_tx, host_ack;
    logic [6:0] my_addr;
    logic       byte_done, addr_hit;

    smb_regbank #(
        .N_REGS(N_REGS), .DW(DW), .RO_MASK(RO_MASK),
        .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST), .RO_BASE(RO_BASE)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .cnt_val(cnt_val), .regs_flat(reg_q_o),
        .wr_stb(reg_wr_stb_o), .rd_stb(reg_rd_stb_o)
    );

    assign my_addr   = BASE_ADDR ^ (7'(addr_sel_i) << SEL_LSB);
    assign addr_hit  = (shreg[7:1] == my_addr);
    assign byte_done = scl_fall && (bitn == 4'd8);
    assign cur_byte  = reg_q_o[idx*DW +: DW];
    assign load_byte = first_tx ? cnt_val : cur_byte;

    // next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:      state_n = state;
            ST_RX_ADDR:   if (byte_done) state_n = addr_hit ? ST_ACK_DRV : ST_WAIT_STOP;
            ST_RX_INDEX,
            ST_RX_COUNT:  if (byte_done) state_n = ST_ACK_DRV;
            ST_RX_DATA:   if (byte_done) state_n = (left != '0) ? ST_ACK_DRV : ST_WAIT_STOP;
            ST_ACK_DRV:   if (scl_fall) state_n = after;
            ST_TX_BYTE:   if (scl_fall && txn == 4'd8) state_n = ST_ACK_GET;
            ST_ACK_GET:   if (scl_fall) state_n = host_ack ? ST_TX_BYTE : ST_WAIT_STOP;
            ST_WAIT_STOP: state_n = state;
            default:      state_n = ST_IDLE;
        endcase
        if (stop_det)  state_n = ST_IDLE;
        if (start_det) state_n = ST_RX_ADDR;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // datapath and bus drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitn <= '0; txn <= '0; shreg <= '0; txsh <= '0; left <= '0;
            idx <= '0; wr_idx <= '0; rd_idx <= '0; wr_data <= '0;
            wr_en <= 1'b0; rd_en <= 1'b0; first_tx <= 1'b0; host_ack <= 1'b0;
            after <= ST_IDLE; sda_oe_o <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            rd_en <= 1'b0;
            if (start_det || stop_det) begin
                bitn     <= '0;
                sda_oe_o <= 1'b0;
            end else begin
                unique case (state)
                    ST_RX_ADDR, ST_RX_INDEX, ST_RX_COUNT, ST_RX_DATA: begin
                        if (scl_rise && bitn < 4'd8) begin
                            shreg <= {shreg[6:0], sda_s};
                            bitn  <= bitn + 4'd1;
                        end else if (byte_done) begin
                            bitn <= '0;
                            if (state_n == ST_ACK_DRV) sda_oe_o <= 1'b1;
                            if (state == ST_RX_ADDR) begin
                                after    <= shreg[0] ? ST_TX_BYTE : ST_RX_INDEX;
                                first_tx <= 1'b1;
                            end else if (state == ST_RX_INDEX) begin
                                idx   <= shreg[IW-1:0];
                                after <= ST_RX_COUNT;
                            end else if (state == ST_RX_COUNT) begin
                                left  <= shreg;
                                after <= ST_RX_DATA;
                            end else if (left != '0) begin
                                wr_en   <= 1'b1;
                                wr_idx  <= idx;
                                wr_data <= shreg;
                                idx     <= idx + 1'b1;
                                left    <= left - 8'd1;
                                after   <= ST_RX_DATA;
                            end
                        end
                    end
                    ST_ACK_DRV, ST_ACK_GET: begin
                        if (state == ST_ACK_GET && scl_rise) host_ack <= ~sda_s;
                        if (scl_fall) begin
                            sda_oe_o <= 1'b0;
                            if (state_n == ST_TX_BYTE) begin
                                txsh     <= load_byte;
                                sda_oe_o <= ~load_byte[7];
                                txn      <= 4'd1;
                                first_tx <= 1'b0;
                                if (!first_tx) begin
                                    rd_en  <= 1'b1;
                                    rd_idx <= idx;
                                    idx    <= idx + 1'b1;
                                end
                            end
                        end
                    end
                    ST_TX_BYTE: begin
                        if (scl_fall) begin
                            if (txn < 4'd8) begin
                                sda_oe_o <= ~txsh[6];
                                txsh     <= txsh << 1;
                                txn      <= txn + 4'd1;
                            end else begin
                                sda_oe_o <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_START_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RX_ADDR && bitn == 4'd0)); // R2
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe_o)); // R2
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s); // R3
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK_DRV) |-> sda_oe_o); // R3
    AST_QUIET_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_WAIT_STOP) |-> !sda_oe_o); // R10
    AST_BITN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bitn <= 4'd8); // R4
endmodule

// File: tb/sim_smb_blkreg_target.sv
module sim_smb_blkreg_target;
    localparam int Q = 6;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, hsda = 1'b1;
    logic [1:0] sel = 2'b00;
    logic sda_oe;
    logic [127:0] regq;
    logic [15:0] wstb, rstb;
    wire sda_bus = hsda & ~sda_oe;

    int n_tests = 0, n_fail = 0, r3_bad = 0;
    bit done = 0;
    logic [7:0] model [16];
    int wcnt [16], rcnt [16], ewc [16], erc [16];
    logic [7:0] wbuf [16];
    logic prev_oe = 1'b0;

    always #2 clk = ~clk;

    smb_blkreg_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .addr_sel_i(sel), .reg_q_o(regq), .reg_wr_stb_o(wstb), .reg_rd_stb_o(rstb)
    );

    always @(posedge clk) begin
        for (int i = 0; i < 16; i++) begin
            if (wstb[i]) wcnt[i]++;
            if (rstb[i]) rcnt[i]++;
        end
    end

    // R3: drive changes must only happen with SCL low
    always @(negedge clk) begin
        if (rst_n && sda_oe !== prev_oe && scl) r3_bad++;
        prev_oe <= sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        tick(Q); hsda = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        tick(Q); hsda = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_bus; tick(Q); scl = 1'b0;
    endtask

    task automatic do_start;
        tick(Q); hsda = 1'b1; tick(Q); scl = 1'b1; tick(Q); hsda = 1'b0; tick(Q); scl = 1'b0;
    endtask

    task automatic do_stop;
        tick(Q); hsda = 1'b0; tick(Q); scl = 1'b1; tick(Q); hsda = 1'b1; tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic a1, a2;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        tick(Q); hsda = 1'b1; tick(Q); scl = 1'b1;
        tick(1); a1 = sda_bus; tick(2*Q-2); a2 = sda_bus; tick(1); scl = 1'b0;
        ack = !a1 && !a2;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
        bit_out(!ack);
    endtask

    task automatic cmp_state(input string req);
        for (int i = 0; i < 16; i++) begin
            chk(req, regq[i*8 +: 8], model[i]);
            chk(req, wcnt[i], ewc[i]);
            chk(req, rcnt[i], erc[i]);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [3:0] n, input int j);
        return (j == 0) ? model[8] : model[4'(n + j - 1)];
    endfunction

    task automatic wr_txn(input logic [7:0] wa, input logic [3:0] n, input logic [7:0] x, input int nb);
        logic a;
        do_start;
        send_byte(wa, a);              chk("R1 write address ACK", a, 1);
        send_byte({4'h0, n}, a);       chk("R4 index ACK", a, 1);
        send_byte(x, a);               chk("R4 count ACK", a, 1);
        for (int k = 0; k < nb; k++) begin
            send_byte(wbuf[k], a);
            if (k < int'(x)) begin
                chk("R4 data ACK", a, 1);
                if (4'(n + k) < 4'd12) begin
                    model[4'(n + k)] = wbuf[k];
                    ewc[4'(n + k)]++;
                end // R6: read-only targets keep their constants
            end else begin
                chk("R7 surplus byte NACK", a, 0);
            end
        end
        do_stop;
        cmp_state("R4 registers after write");
    endtask

    task automatic rd_txn(input logic [3:0] n, input int k, input bit linger);
        logic a;
        logic [7:0] d;
        do_start;
        send_byte(8'h6C, a);     chk("R8 write address ACK", a, 1);
        send_byte({4'h0, n}, a); chk("R8 index ACK", a, 1);
        do_start;
        send_byte(8'h6D, a);     chk("R8 read address ACK", a, 1);
        for (int j = 0; j < k; j++) begin
            recv_byte(j < k - 1, d);
            if (j == 0) chk("R9 leading count byte", d, exp_rd(n, j));
            else begin
                chk("R8 register byte", d, exp_rd(n, j));
                erc[4'(n + j - 1)]++;
            end
        end
        if (linger) begin
            recv_byte(1'b0, d);
            chk("R10 SDA released after NACK", d, 8'hFF);
        end
        do_stop;
        cmp_state("R8 strobes after read");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic a;
        int seed;
        seed = $urandom(32'd7391);
        for (int i = 0; i < 16; i++) begin
            model[i] = (i >= 12) ? 8'(8'hC0 + i) : ((i == 8) ? 8'd8 : 8'd0);
            ewc[i] = 0; erc[i] = 0; wcnt[i] = 0; rcnt[i] = 0;
        end
        tick(5); rst_n = 1'b1; tick(5);

        // R11 reset state
        chk("R11 SDA released", sda_oe, 0);
        cmp_state("R11 reset values");

        // R1 foreign address, then trailing byte ignored
        do_start;
        send_byte(8'hA0, a); chk("R1 foreign address NACK", a, 0);
        send_byte(8'h55, a); chk("R1 bytes after foreign address ignored", a, 0);
        do_stop;
        cmp_state("R1 registers untouched");

        // R1 address select pins
        sel = 2'b01;
        do_start; send_byte(8'h6C, a); chk("R1 base address refused with pins set", a, 0); do_stop;
        wbuf[0] = 8'h3A;
        wr_txn(8'h4C, 4'd2, 8'd1, 1);
        sel = 2'b00;

        // R5 R6 wrap across read-only registers
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        wr_txn(8'h6C, 4'd14, 8'd4, 4);
        chk("R5 wrapped write reached reg 1", regq[15:8], 8'h44);
        chk("R6 reg 14 constant", regq[14*8 +: 8], 8'hCE);

        // R7 surplus bytes
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3; wbuf[3] = 8'hA4;
        wr_txn(8'h6C, 4'd4, 8'd2, 4);
        chk("R7 reg 6 unchanged", regq[6*8 +: 8], 8'h00);

        // R9 program the count register, then read
        wbuf[0] = 8'h03;
        wr_txn(8'h6C, 4'd8, 8'd1, 1);
        rd_txn(4'd14, 4, 1'b0);
        rd_txn(4'd0, 3, 1'b1);   // R10

        // R2 start aborts a partial byte
        do_start;
        bit_out(1'b0); bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
        wbuf[0] = 8'h5C;
        wr_txn(8'h6C, 4'd9, 8'd1, 1);
        chk("R2 write after aborted byte", regq[9*8 +: 8], 8'h5C);
        // R2 stop aborts mid data byte
        do_start;
        send_byte(8'h6C, a); send_byte(8'h0A, a); send_byte(8'h01, a);
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
        do_stop;
        chk("R2 idle and released after stop", sda_oe, 0);
        cmp_state("R2 no write from aborted byte");

        // random mix
        for (int t = 0; t < 18; t++) begin
            logic [3:0] n;
            logic [7:0] x;
            int nb;
            n = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 1) == 0) begin
                x  = 8'($urandom_range(0, 5));
                nb = int'(x) + int'($urandom_range(0, 1));
                for (int k = 0; k < 16; k++) wbuf[k] = 8'($urandom);
                wr_txn(8'h6C, n, x, nb);
            end else begin
                rd_txn(n, int'($urandom_range(1, 6)), 1'b0);
            end
        end

        chk("R3 drive changes only with SCL low", r3_bad, 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule